// File: doc/BRIEF.md
# Double-Buffered 8-bit PWM Generator

This block produces a pulse-width-modulated output from an 8-bit up-counter. The counter advances on every clock cycle in which a prescaler tick is present, while a run bit is set. A period lasts 2^n − 1 ticks, with n picked as 6, 7 or 8 by a mode field. A compare value sets the point inside the period where the output flop flips. The end of each period flips the flop again, so a flop that starts cleared gives a low phase followed by a high phase in every period.

Compare values arrive through a one-cycle write strobe. When buffering is off, a write changes the live compare value at once. When buffering is on, a write only fills a holding register. That value moves into the live compare register at the end of the period. Software can therefore change the duty cycle at any time, including for very short duties, without getting a truncated or doubled pulse. A clear strobe resets the output flop, for use before the timer is started. Prescaling and clock gearing are outside this block; the tick input stands in for them.

Top module: `pwm8_dbuf`

## Requirements
- R1: The period is 2^n − 1 ticks. mode=0 selects n=6 (63 ticks), mode=1 selects n=7 (127 ticks), and mode=2 selects n=8 (255 ticks). The counter takes the values 0 to 2^n − 2, and the tick that would bring it to 2^n − 1 is the end-of-period event.
- R2: With inversion enabled, the output flop flips on the tick where the counter becomes equal to the live compare value, and flips again at the end-of-period event. Starting from a cleared flop with a compare value c in 1 to 2^n − 2, the output is high exactly while the counter is in c to 2^n − 2.
- R3: After the end-of-period event the counter continues from zero, so consecutive periods repeat the same waveform.
- R4: The counter advances only on clock cycles where tick is high. With tick low, the counter and the output hold.
- R5: While run is low, the counter is held at zero and the output flop keeps its value. When run is raised again, counting restarts from zero.
- R6: With inversion disabled, the output flop never changes, except through the clear strobe.
- R7: A clear strobe makes the output low at the next clock edge. It has priority over any flip in that cycle.
- R8: With buffering off, a compare write takes effect at the next clock edge, within the current period.
- R9: With buffering on, a compare write leaves the live compare value unchanged until the next end-of-period event, which loads the held value.
- R10: After reset the counter, the compare value, the holding register and the output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count enable, one clock wide |
| run | input | 1 | 1 = count; 0 = stop and hold the counter at zero |
| mode | input | 2 | Period select: 0→n=6, 1→n=7, 2 or 3→n=8 |
| bufEn | input | 1 | 1 = compare writes go through the holding register |
| invEn | input | 1 | 1 = allow the output flop to flip on compare and end-of-period |
| ffClear | input | 1 | Strobe that clears the output flop |
| cmpWrEn | input | 1 | Compare write strobe |
| cmpWrData | input | 8 | Compare write value |
| pwmOut | output | 1 | PWM output |

## Verification
The in-design assertions assume that mode changes only while run is low. The check that the counter stays below its terminal value compares the counter against the currently selected period. That check is therefore enabled only while running. Every bench scenario sets mode in its preparation step, with run held low, and keeps it fixed until the next preparation. Beyond that, the stimulus keeps each input at one value for a whole clock cycle. It drives inputs on the falling edge and applies each strobe for a single cycle.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int CNT_W   = 8;
  localparam int MODE_W  = 2;
  localparam int N_SPAN  = 2;            // n ranges CNT_W-N_SPAN .. CNT_W

  typedef struct packed {
    logic             adv;               // counter steps this cycle
    logic             ovf;               // end-of-period event this cycle
    logic [CNT_W-1:0] nextCnt;           // value counter would reach
  } pwmStrobe_t;
endpackage

// File: rtl/pwm8_ctrl.sv
module pwm8_ctrl
  import pwm8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              run,
  input  logic [MODE_W-1:0] mode,
  output pwmStrobe_t        strb
);
  localparam int SH_W = $clog2(N_SPAN + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] topVal;
  logic [SH_W-1:0]  shiftAmt;
  logic [CNT_W-1:0] incVal;
  logic             advance;
  logic             atTop;

  always_comb begin
    if (int'(mode) >= N_SPAN) shiftAmt = '0;
    else                      shiftAmt = SH_W'(N_SPAN - int'(mode));
    topVal  = {CNT_W{1'b1}} >> shiftAmt;
    incVal  = count + 1'b1;
    advance = run && tick;
    atTop   = (incVal == topVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        count <= '0;
    else if (!run)    count <= '0;
    else if (advance) count <= atTop ? '0 : incVal;
  end

  assign strb.adv     = advance;
  assign strb.ovf     = advance && atTop;
  assign strb.nextCnt = incVal;

  // R1
  cnt_below_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (count < topVal));
  // R5
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (count == '0));
  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tick) ##1 run |-> $stable(count));
endmodule

// File: rtl/pwm8_datapath.sv
module pwm8_datapath
  import pwm8_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strb,
  input  logic             bufEn,
  input  logic             invEn,
  input  logic             ffClear,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  output logic             pwmOut
);
  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0] holdReg;
  logic             outFf;
  logic             match;
  logic             flip;

  always_comb begin
    match = strb.adv && !strb.ovf && (strb.nextCnt == cmpReg);
    flip  = invEn && (match || strb.ovf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg  <= '0;
      holdReg <= '0;
    end else begin
      if (cmpWrEn) holdReg <= cmpWrData;
      if (cmpWrEn && !bufEn)      cmpReg <= cmpWrData;
      else if (bufEn && strb.ovf) cmpReg <= holdReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        outFf <= 1'b0;
    else if (ffClear) outFf <= 1'b0;
    else if (flip)    outFf <= ~outFf;
  end

  assign pwmOut = outFf;

  // R7
  clear_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ffClear |=> !pwmOut);
  // R6
  no_inv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!invEn && !ffClear) |=> $stable(pwmOut));
  // R9
  buf_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufEn && !strb.ovf) |=> $stable(cmpReg));
endmodule

// File: rtl/pwm8_dbuf.sv
module pwm8_dbuf
  import pwm8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              run,
  input  logic [MODE_W-1:0] mode,
  input  logic              bufEn,
  input  logic              invEn,
  input  logic              ffClear,
  input  logic              cmpWrEn,
  input  logic [CNT_W-1:0]  cmpWrData,
  output logic              pwmOut
);
  pwmStrobe_t strb;

  pwm8_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick),
    .run  (run),
    .mode (mode),
    .strb (strb)
  );

  pwm8_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bufEn     (bufEn),
    .invEn     (invEn),
    .ffClear   (ffClear),
    .cmpWrEn   (cmpWrEn),
    .cmpWrData (cmpWrData),
    .pwmOut    (pwmOut)
  );
endmodule

// File: tb/tb_pwm8_dbuf.sv
module tb_pwm8_dbuf;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       run = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       bufEn = 1'b0;
  logic       invEn = 1'b1;
  logic       ffClear = 1'b0;
  logic       cmpWrEn = 1'b0;
  logic [7:0] cmpWrData = 8'd0;
  logic       pwmOut;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  pwm8_dbuf dut (
    .clk(clk), .rstN(rstN), .tick(tick), .run(run), .mode(mode),
    .bufEn(bufEn), .invEn(invEn), .ffClear(ffClear), .cmpWrEn(cmpWrEn),
    .cmpWrData(cmpWrData), .pwmOut(pwmOut)
  );

  always #10 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Edge index i counts edges since run rose; count = (i - shift) mod top.
  task automatic runSpan(input int first, input int last, input int top,
                         input int cmp, input int shift, input bit inv,
                         input string req);
    int bad = 0;
    int firstBad = -1;
    for (int i = first; i <= last; i++) begin
      bit e;
      step();
      e = (((i - shift) % top) >= cmp) ^ inv;
      if (pwmOut !== e) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    end
    check(bad == 0, req, firstBad, -1);
  endtask

  task automatic prep(input logic [1:0] m, input int cmp);
    run = 1'b0; mode = m; bufEn = 1'b0; invEn = 1'b1; tick = 1'b1;
    cmpWrEn = 1'b1; cmpWrData = 8'(cmp); ffClear = 1'b1;
    step();
    cmpWrEn = 1'b0; ffClear = 1'b0; run = 1'b1;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    step();
    check(pwmOut === 1'b0, "R10 reset output", int'(pwmOut), 0);
    rstN = 1'b1;
    step();
    // R10: compare and holding register are zero, so with run low nothing moves
    check(pwmOut === 1'b0, "R10 idle after reset", int'(pwmOut), 0);
  endtask

  task automatic tMode7();
    prep(2'd1, 72);
    runSpan(1, 127, 127, 72, 0, 1'b0, "R2 n=7 cmp=72 period 1");
    runSpan(128, 254, 127, 72, 0, 1'b0, "R3 n=7 repeat period 2");
  endtask

  task automatic tMode6();
    prep(2'd0, 10);
    runSpan(1, 126, 63, 10, 0, 1'b0, "R1 n=6 two periods of 63");
  endtask

  task automatic tMode8();
    prep(2'd2, 200);
    runSpan(1, 510, 255, 200, 0, 1'b0, "R1 n=8 two periods of 255");
  endtask

  task automatic tNoInv();
    prep(2'd1, 10);
    invEn = 1'b0;
    runSpan(1, 254, 127, 127, 0, 1'b0, "R6 inversion off holds low");
    invEn = 1'b1;
  endtask

  task automatic tBuffered();
    prep(2'd1, 72);
    runSpan(1, 10, 127, 72, 0, 1'b0, "R9 before buffered write");
    bufEn = 1'b1; cmpWrEn = 1'b1; cmpWrData = 8'd32;
    runSpan(11, 11, 127, 72, 0, 1'b0, "R9 write cycle");
    cmpWrEn = 1'b0;
    runSpan(12, 127, 127, 72, 0, 1'b0, "R9 old compare kept to period end");
    runSpan(128, 254, 127, 32, 0, 1'b0, "R9 new compare after end event");
    bufEn = 1'b0;
  endtask

  task automatic tDirect();
    prep(2'd1, 72);
    runSpan(1, 10, 127, 72, 0, 1'b0, "R8 before direct write");
    cmpWrEn = 1'b1; cmpWrData = 8'd100;
    runSpan(11, 11, 127, 100, 0, 1'b0, "R8 write cycle");
    cmpWrEn = 1'b0;
    runSpan(12, 127, 127, 100, 0, 1'b0, "R8 new compare in same period");
  endtask

  task automatic tTickGate();
    prep(2'd1, 72);
    tick = 1'b0;
    runSpan(1, 20, 127, 127, 0, 1'b0, "R4 no tick keeps output low");
    tick = 1'b1;
    runSpan(21, 147, 127, 72, 20, 1'b0, "R4 counting resumes from 1");
  endtask

  task automatic tStop();
    prep(2'd1, 72);
    runSpan(1, 80, 127, 72, 0, 1'b0, "R5 run before stop");
    run = 1'b0;
    begin
      int bad = 0;
      for (int k = 0; k < 5; k++) begin
        step();
        if (pwmOut !== 1'b1) bad++;
      end
      check(bad == 0, "R5 output held while stopped", bad, 0);
    end
    run = 1'b1;
    // flop still high; restart from zero flips it low at count 72
    runSpan(1, 127, 127, 72, 0, 1'b1, "R5 restart from zero");
  endtask

  task automatic tClear();
    prep(2'd1, 72);
    runSpan(1, 90, 127, 72, 0, 1'b0, "R7 run to high phase");
    ffClear = 1'b1;
    step();
    check(pwmOut === 1'b0, "R7 clear strobe", int'(pwmOut), 0);
    ffClear = 1'b0;
    step();
    check(pwmOut === 1'b0, "R7 stays low after clear", int'(pwmOut), 0);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tMode7();
    tMode6();
    tMode8();
    tNoInv();
    tBuffered();
    tDirect();
    tTickGate();
    tStop();
    tClear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule